// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through SRAM Core

This block is a synchronous static memory front end that never inserts a dead cycle when it turns from reads to writes or back. A command is captured on a rising clock edge while the active-low clock enable is low. A read places its word on the output one edge later. A write takes its data and byte enables one edge after its address. A two-bit burst counter can continue from the last loaded address for four-word sequences, in either linear or interleaved order. The storage is a reduced-depth register array, 48 bits wide by default, made of six byte lanes.

The bidirectional data bus is split into a data input, a data output and an output-drive flag. The output is driven only when a read result is pending, the asynchronous output enable is low, and the current cycle is not the data cycle of a write. The edge has no valid/ready handshake. The only back-pressure is the clock enable. Holding it high freezes every internal register, holds the output word, and takes no command or data, so the host may stall at any point and resume. A write that follows a read to the same address is forwarded to the read, so back-to-back traffic needs no gap.

Top module: `zt_sram_core`

## Requirements
- R1: A command loads at a rising edge with `cen_n` low and `adv_ld_n` low. The device is selected only when `sel0_n` is 0, `sel1` is 1 and `sel2_n` is 0; any other combination deselects it, and nothing is read or written. `wr_n` 0 picks a write and 1 picks a read.
- R2: For a write, `din` and `bw_n` are sampled at the next enabled edge after the address edge. Lane i is bits 8i+7 down to 8i, and it is stored only if `bw_n[i]` is 0 at that edge.
- R3: A read captured at one enabled edge drives the stored word on `dout` with `dout_en` high, starting after the next enabled edge. This holds only while `oe_n` is low. `oe_n` high removes the drive at once, without waiting for the clock.
- R4: During a burst continuation (`adv_ld_n` high, `cen_n` low, device selected), the chip selects and `wr_n` are ignored, and the read or write type loaded at burst start is kept.
- R5: With `burst_ilv` at 0, each continuation adds one, modulo four, to address bits 1:0 and leaves the upper bits unchanged. The sequence wraps past four steps.
- R6: With `burst_ilv` at 1, continuation k of a burst uses the start's bits 1:0 XOR (k mod 4), and the upper bits are unchanged.
- R7: An edge with `cen_n` high changes no internal state: no command, no data, no memory update. The output keeps its word.
- R8: `dout_en` is 0, and `dout` reads zero, whenever no read result is pending. This covers after a deselect, after a write, and in the first cycle after a load. `dout_en` is also 0 during the data cycle of a write, even when a read result is pending and `oe_n` is low.
- R9: A write whose byte enables are all 1 changes no memory contents. A read with `oe_n` high changes nothing and leaves the output undriven.
- R10: Once deselected, the device stays deselected through continuation edges. No write is done, even if selects and `wr_n` would call for one, until `adv_ld_n` is driven low.
- R11: A read loaded at the edge where a write's data is sampled, to the same address, returns the newly written lanes merged with the old contents of the unwritten lanes.
- R12: While `rst_n` is low, `dout_en` is 0, `dout` is zero and the device is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| cen_n | input | 1 | Active-low clock enable; high stalls everything |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Low selects write at load |
| adv_ld_n | input | 1 | Low loads a command, high continues a burst |
| addr | input | ADDR_W | Word address |
| bw_n | input | LANES | Active-low byte-lane write enables, data cycle |
| din | input | LANES*LANE_W | Write data, sampled in the data cycle |
| oe_n | input | 1 | Asynchronous active-low output enable |
| burst_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | Output drive flag for the external bus |

## Verification
The collision that matters most is a read's output cycle landing on the data cycle of a write loaded at the next edge. Both want the bus in the same cycle, and the write must win. The bench issues a read immediately followed by a write, keeps `oe_n` low, and expects `dout_en` low in that cycle. Forwarding is provoked the same way: a read to the address whose write data is sampled at the same edge, with partial byte enables, is judged against a model that applies the write before the read looks up memory. Stalls are inserted both under a driving read and inside a pending write data cycle, and the output and the stored word are then compared every cycle.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  localparam int unsigned BURST_BITS = 2;

  typedef logic [BURST_BITS-1:0] burst_idx_t;

  // Low address bits for a burst slot: XOR order or modulo-four add.
  function automatic burst_idx_t burst_slot(input burst_idx_t start,
                                            input burst_idx_t step,
                                            input logic       xor_order);
    burst_idx_t res;
    if (xor_order) res = start ^ step;
    else           res = burst_idx_t'(start + step);
    return res;
  endfunction

endpackage

// File: rtl/zt_cmd_stage.sv
// Command capture and burst address generation (ADDR_W must be >= 2).
module zt_cmd_stage
  import zt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              wr_n,
  input  logic              adv_ld_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              burst_ilv,
  output logic              act_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic              sel_all;
  logic              act_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  burst_idx_t        start_q;
  burst_idx_t        step_q;
  burst_idx_t        step_nx;

  assign sel_all = !sel0_n && sel1 && !sel2_n;
  assign step_nx = step_q + burst_idx_t'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      start_q <= '0;
      step_q  <= '0;
    end else if (!cen_n) begin
      if (!adv_ld_n) begin
        act_q   <= sel_all;
        wr_q    <= sel_all && !wr_n;
        addr_q  <= addr_i;
        start_q <= addr_i[BURST_BITS-1:0];
        step_q  <= '0;
      end else if (act_q) begin
        step_q                 <= step_nx;
        addr_q[BURST_BITS-1:0] <= burst_slot(start_q, step_nx, burst_ilv);
      end
    end
  end

  assign act_o  = act_q;
  assign wr_o   = wr_q;
  assign addr_o = addr_q;

  // R7: a masked edge leaves the command state untouched
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(act_q) && $stable(wr_q) && $stable(addr_q)));

  // R4: a continuation keeps the device selected and the access type
  a_r4_type_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld_n && act_q) |=> (act_q && (wr_q == $past(wr_q))));

  // R10: a continuation while deselected stays deselected
  a_r10_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld_n && !act_q) |=> !act_q);

  // R5: linear order steps the low bits by one
  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld_n && act_q && !burst_ilv) |=>
      (addr_q[BURST_BITS-1:0] == $past(addr_q[BURST_BITS-1:0]) + 2'd1));

  // R6: any continuation leaves the upper address bits alone
  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld_n && act_q) |=>
      (addr_q[ADDR_W-1:BURST_BITS] == $past(addr_q[ADDR_W-1:BURST_BITS])));

  // R1: a load with any select inactive deselects
  a_r1_select_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld_n && !(!sel0_n && sel1 && !sel2_n)) |=> !act_q);

endmodule

// File: rtl/zt_wr_buffer.sv
// Holds one write between its data edge and its commit to the array.
module zt_wr_buffer #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cen_n,
  input  logic                     cap_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [LANES*LANE_W-1:0]  din_i,
  input  logic [LANES-1:0]         bw_n_i,
  output logic                     pend_v_o,
  output logic [ADDR_W-1:0]        pend_addr_o,
  output logic [LANES*LANE_W-1:0]  pend_data_o,
  output logic [LANES-1:0]         pend_mask_o
);

  logic any_lane;

  assign any_lane = !(&bw_n_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_o    <= 1'b0;
      pend_addr_o <= '0;
      pend_data_o <= '0;
      pend_mask_o <= '0;
    end else if (!cen_n) begin
      pend_v_o    <= cap_i && any_lane;
      pend_addr_o <= addr_i;
      pend_data_o <= din_i;
      pend_mask_o <= cap_i ? ~bw_n_i : '0;
    end
  end

  // R9: all byte enables high yields no pending write
  a_r9_dummy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && cap_i && (&bw_n_i)) |=> !pend_v_o);

  // R2: the lane mask is the complement of the data-cycle enables
  a_r2_mask_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && cap_i && !(&bw_n_i)) |=> (pend_v_o && (pend_mask_o == ~$past(bw_n_i))));

endmodule

// File: rtl/zt_lane_array.sv
// Storage: one register array per byte lane.
module zt_lane_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 6
) (
  input  logic                     clk,
  input  logic                     cen_n,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [LANES*LANE_W-1:0]  wdata_i,
  input  logic [LANES-1:0]         wmask_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic [LANES*LANE_W-1:0]  rdata_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (!cen_n && we_i && wmask_i[l])
        cells[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = cells[raddr_i];
  end

endmodule

// File: rtl/zt_read_stage.sv
// Output register with write forwarding and bus drive control.
module zt_read_stage #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cen_n,
  input  logic                     rd_cap_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  input  logic [LANES*LANE_W-1:0]  arr_data_i,
  input  logic                     pend_v_i,
  input  logic [ADDR_W-1:0]        pend_addr_i,
  input  logic [LANES*LANE_W-1:0]  pend_data_i,
  input  logic [LANES-1:0]         pend_mask_i,
  input  logic                     wr_data_cycle_i,
  input  logic                     oe_n,
  output logic [LANES*LANE_W-1:0]  dout_o,
  output logic                     dout_en_o
);

  logic                     hit;
  logic [LANES*LANE_W-1:0]  merged;
  logic [LANES*LANE_W-1:0]  q;
  logic                     rv_q;

  assign hit = pend_v_i && (pend_addr_i == rd_addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign merged[l*LANE_W +: LANE_W] = (hit && pend_mask_i[l]) ?
        pend_data_i[l*LANE_W +: LANE_W] : arr_data_i[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      q    <= '0;
    end else if (!cen_n) begin
      rv_q <= rd_cap_i;
      q    <= merged;
    end
  end

  assign dout_en_o = rv_q && !oe_n && !wr_data_cycle_i;
  assign dout_o    = dout_en_o ? q : '0;

  // R11: a full-lane pending write to the read address is what the read returns
  a_r11_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && rd_cap_i && pend_v_i && (pend_addr_i == rd_addr_i) && (&pend_mask_i))
      |=> (q == $past(pend_data_i)));

endmodule

// File: rtl/zt_sram_core.sv
module zt_sram_core #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cen_n,
  input  logic                     sel0_n,
  input  logic                     sel1,
  input  logic                     sel2_n,
  input  logic                     wr_n,
  input  logic                     adv_ld_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES-1:0]         bw_n,
  input  logic [LANES*LANE_W-1:0]  din,
  input  logic                     oe_n,
  input  logic                     burst_ilv,
  output logic [LANES*LANE_W-1:0]  dout,
  output logic                     dout_en
);

  localparam int unsigned DATA_W = LANES * LANE_W;

  logic              cur_act;
  logic              cur_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic              wr_cycle;
  logic              rd_cycle;
  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic [LANES-1:0]  pend_mask;
  logic [DATA_W-1:0] arr_data;

  assign wr_cycle = cur_act && cur_wr;
  assign rd_cycle = cur_act && !cur_wr;

  zt_cmd_stage #(.ADDR_W(ADDR_W)) i_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cen_n     (cen_n),
    .sel0_n    (sel0_n),
    .sel1      (sel1),
    .sel2_n    (sel2_n),
    .wr_n      (wr_n),
    .adv_ld_n  (adv_ld_n),
    .addr_i    (addr),
    .burst_ilv (burst_ilv),
    .act_o     (cur_act),
    .wr_o      (cur_wr),
    .addr_o    (cur_addr)
  );

  zt_wr_buffer #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_wbuf (
    .clk         (clk),
    .rst_n       (rst_n),
    .cen_n       (cen_n),
    .cap_i       (wr_cycle),
    .addr_i      (cur_addr),
    .din_i       (din),
    .bw_n_i      (bw_n),
    .pend_v_o    (pend_v),
    .pend_addr_o (pend_addr),
    .pend_data_o (pend_data),
    .pend_mask_o (pend_mask)
  );

  zt_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_array (
    .clk     (clk),
    .cen_n   (cen_n),
    .we_i    (pend_v),
    .waddr_i (pend_addr),
    .wdata_i (pend_data),
    .wmask_i (pend_mask),
    .raddr_i (cur_addr),
    .rdata_o (arr_data)
  );

  zt_read_stage #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_rd (
    .clk             (clk),
    .rst_n           (rst_n),
    .cen_n           (cen_n),
    .rd_cap_i        (rd_cycle),
    .rd_addr_i       (cur_addr),
    .arr_data_i      (arr_data),
    .pend_v_i        (pend_v),
    .pend_addr_i     (pend_addr),
    .pend_data_i     (pend_data),
    .pend_mask_i     (pend_mask),
    .wr_data_cycle_i (wr_cycle),
    .oe_n            (oe_n),
    .dout_o          (dout),
    .dout_en_o       (dout_en)
  );

  // R8: no drive while a write's data cycle is open
  a_r8_write_cycle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_act && cur_wr) |-> !dout_en);

  // R8: a deselect followed by an enabled edge leaves the bus undriven
  a_r8_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && $past(!cen_n && !adv_ld_n && !(!sel0_n && sel1 && !sel2_n))) |=> !dout_en);

endmodule

// File: tb/test_zt_sram_core.sv
module test_zt_sram_core;

  localparam logic [2:0] GOOD = 3'b010;  // {sel0_n, sel1, sel2_n}
  localparam logic [2:0] BAD  = 3'b000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cen_n = 1'b1;
  logic [2:0]  sel = BAD;
  logic        wr_n = 1'b1;
  logic        adv_ld_n = 1'b0;
  logic [9:0]  addr = '0;
  logic [5:0]  bw_n = '1;
  logic [47:0] din = '0;
  logic        oe_r = 1'b0;
  logic        ilv = 1'b0;
  logic [47:0] dout;
  logic        dout_en;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cycles  = 0;
  string cur_req = "R12";

  always #10 clk = ~clk;

  zt_sram_core i_zt_sram_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .cen_n     (cen_n),
    .sel0_n    (sel[2]),
    .sel1      (sel[1]),
    .sel2_n    (sel[0]),
    .wr_n      (wr_n),
    .adv_ld_n  (adv_ld_n),
    .addr      (addr),
    .bw_n      (bw_n),
    .din       (din),
    .oe_n      (oe_r),
    .burst_ilv (ilv),
    .dout      (dout),
    .dout_en   (dout_en)
  );

  // ---------------- reference model ----------------
  logic [47:0] mv [int];
  logic [47:0] mk [int];
  bit          m_act, m_wr, m_rv;
  int          m_addr, m_start, m_cnt;
  logic [47:0] m_rd, m_rk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_wr = 0; m_rv = 0; m_cnt = 0; m_addr = 0; m_start = 0;
      m_rd = '0; m_rk = '0;
    end else if (!cen_n) begin
      if (m_act && !m_wr) begin
        m_rv = 1;
        m_rd = mv.exists(m_addr) ? mv[m_addr] : '0;
        m_rk = mk.exists(m_addr) ? mk[m_addr] : '0;
      end else begin
        m_rv = 0;
      end
      if (m_act && m_wr) begin
        logic [47:0] lm;
        lm = '0;
        for (int l = 0; l < 6; l++) if (!bw_n[l]) lm[l*8 +: 8] = 8'hff;
        if (!mv.exists(m_addr)) begin mv[m_addr] = '0; mk[m_addr] = '0; end
        mv[m_addr] = (mv[m_addr] & ~lm) | (din & lm);
        mk[m_addr] = mk[m_addr] | lm;
      end
      if (!adv_ld_n) begin
        m_act = (sel == GOOD);
        m_wr = !wr_n;
        m_start = int'(addr);
        m_addr = int'(addr);
        m_cnt = 0;
      end else if (m_act) begin
        int low;
        m_cnt = (m_cnt + 1) % 4;
        low = ilv ? ((m_start % 4) ^ m_cnt) : (((m_start % 4) + m_cnt) % 4);
        m_addr = (m_start / 4) * 4 + low;
      end
    end
  end

  task automatic chk(input bit ok, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_en;
      exp_en = m_rv && !oe_r && !(m_act && m_wr);
      chk(dout_en === exp_en, "dout_en", {47'd0, dout_en}, {47'd0, exp_en});
      if (exp_en) chk(((dout ^ m_rd) & m_rk) == '0, "dout", dout, m_rd);
      else        chk(dout === '0, "idle dout", dout, '0);
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_fail++;
      $display("FAIL %s watchdog: actual %0d expected %0d", cur_req, cycles, 5000);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [47:0] pat(input int k);
    return {16'(k * 7 + 3), 16'(k * 13 + 5), 16'(k * 29 + 11)};
  endfunction

  task automatic cyc(input logic c_n, input logic [2:0] s, input logic w_n,
                     input logic al_n, input logic [9:0] a,
                     input logic [5:0] b_n, input logic [47:0] d);
    @(posedge clk);
    #3;
    cen_n = c_n; sel = s; wr_n = w_n; adv_ld_n = al_n;
    addr = a; bw_n = b_n; din = d;
  endtask

  task automatic wcmd(input logic [9:0] a, input logic [5:0] b_n, input logic [47:0] d);
    cyc(1'b0, GOOD, 1'b0, 1'b0, a, b_n, d);
  endtask
  task automatic rcmd(input logic [9:0] a, input logic [5:0] b_n, input logic [47:0] d);
    cyc(1'b0, GOOD, 1'b1, 1'b0, a, b_n, d);
  endtask
  task automatic dsel(input logic [5:0] b_n, input logic [47:0] d);
    cyc(1'b0, BAD, 1'b1, 1'b0, 10'h0, b_n, d);
  endtask
  task automatic advc(input logic [2:0] s, input logic w_n, input logic [5:0] b_n,
                      input logic [47:0] d);
    cyc(1'b0, s, w_n, 1'b1, 10'h0, b_n, d);
  endtask
  task automatic stall(input logic [5:0] b_n, input logic [47:0] d);
    cyc(1'b1, GOOD, 1'b0, 1'b0, 10'h3ff, b_n, d);
  endtask

  initial begin
    // R12: reset state
    repeat (2) @(negedge clk);
    chk(dout_en === 1'b0, "reset dout_en", {47'd0, dout_en}, '0);
    chk(dout === '0, "reset dout", dout, '0);
    @(posedge clk); #3; rst_n = 1'b1;

    cur_req = "R1";
    wcmd(10'h013, '1, '0); dsel(6'h00, pat(1));
    wcmd(10'h010, '1, '0); wcmd(10'h011, 6'h00, pat(2)); wcmd(10'h012, 6'h00, pat(3));
    cyc(1'b0, 3'b110, 1'b0, 1'b0, 10'h013, 6'h00, pat(4));
    cyc(1'b0, 3'b011, 1'b0, 1'b0, 10'h013, 6'h00, pat(5));
    cyc(1'b0, 3'b000, 1'b0, 1'b0, 10'h013, 6'h00, pat(6));
    dsel(6'h00, pat(7));
    rcmd(10'h010, '1, '0); rcmd(10'h011, '1, '0); rcmd(10'h012, '1, '0); rcmd(10'h013, '1, '0);
    dsel('1, '0); dsel('1, '0);

    cur_req = "R3";
    rcmd(10'h010, '1, '0); rcmd(10'h011, '1, '0);
    oe_r = 1'b1;
    rcmd(10'h012, '1, '0);
    oe_r = 1'b0;
    dsel('1, '0); dsel('1, '0);

    cur_req = "R2";
    wcmd(10'h011, '1, '0); dsel(6'b101010, pat(9));
    rcmd(10'h011, '1, '0); dsel('1, '0); dsel('1, '0);

    cur_req = "R11";
    wcmd(10'h020, '1, '0); rcmd(10'h020, 6'h00, pat(10)); dsel('1, '0);
    wcmd(10'h020, '1, '0); rcmd(10'h020, 6'b110011, pat(11)); dsel('1, '0); dsel('1, '0);

    cur_req = "R8";
    rcmd(10'h010, '1, '0); wcmd(10'h030, '1, '0); dsel(6'h00, pat(12));
    rcmd(10'h030, '1, '0); dsel('1, '0); dsel('1, '0);

    cur_req = "R5";
    wcmd(10'h042, '1, '0);
    for (int k = 0; k < 5; k++) advc(GOOD, 1'b0, 6'h00, pat(13 + k));
    dsel(6'h00, pat(18));
    rcmd(10'h041, '1, '0);
    cur_req = "R4";
    advc(BAD, 1'b0, '1, '0); advc(BAD, 1'b0, '1, '0); advc(3'b111, 1'b0, '1, '0);
    advc(GOOD, 1'b0, '1, '0); advc(GOOD, 1'b0, '1, '0);
    dsel('1, '0); dsel('1, '0);

    cur_req = "R6";
    ilv = 1'b1;
    wcmd(10'h051, '1, '0);
    for (int k = 0; k < 3; k++) advc(BAD, 1'b1, 6'h00, pat(20 + k));
    dsel(6'h00, pat(23));
    rcmd(10'h052, '1, '0);
    for (int k = 0; k < 4; k++) advc(GOOD, 1'b0, '1, '0);
    dsel('1, '0); dsel('1, '0);
    ilv = 1'b0;
    dsel('1, '0);

    cur_req = "R7";
    rcmd(10'h040, '1, '0); advc(GOOD, 1'b1, '1, '0);
    stall(6'h00, pat(24)); stall(6'h00, pat(25));
    advc(GOOD, 1'b1, '1, '0); dsel('1, '0);
    wcmd(10'h060, '1, '0); stall(6'h00, pat(30)); stall(6'h00, pat(31));
    dsel(6'h00, pat(32)); rcmd(10'h060, '1, '0); dsel('1, '0); dsel('1, '0);

    cur_req = "R9";
    wcmd(10'h010, '1, '0); dsel('1, pat(40));
    oe_r = 1'b1;
    rcmd(10'h011, '1, '0); dsel('1, '0);
    oe_r = 1'b0;
    dsel('1, '0); rcmd(10'h010, '1, '0); dsel('1, '0); dsel('1, '0);

    cur_req = "R10";
    dsel('1, '0);
    for (int k = 0; k < 3; k++) advc(GOOD, 1'b0, 6'h00, pat(41 + k));
    dsel(6'h00, pat(44));
    rcmd(10'h042, '1, '0); rcmd(10'h043, '1, '0); rcmd(10'h000, '1, '0);
    dsel('1, '0); dsel('1, '0); dsel('1, '0);

    @(posedge clk); @(negedge clk);
    summary();
    $finish;
  end

endmodule